// File: doc/BRIEF.md
# Sound Generator Host Register Interface

This block sits between a host processor bus and the register file of a three-voice sound generator. The host presents a 5-bit address, write data, an active-low chip select, a read/write direction bit and a bus-phase clock level (`phi2`). The block qualifies these into a write strobe and a read strobe. A one-hot decoder turns the address and the direction into one select line per register. Every transfer moves a byte across a shared internal bus.

Addresses 0x00 to 0x18 hold writable registers that cannot be read back. Addresses 0x19 to 0x1C are read-only and return bytes sampled from the voice logic. Addresses 0x1D to 0x1F are not implemented. The internal bus keeps the byte of the last valid transfer. A read of any address that cannot be read returns that held byte. An optional idle counter lets the held byte decay to zero. Reset selects every writable register and forces zero onto the internal bus, which clears the whole file through the normal write path.

Top module: `snd_regbus`

## Requirements
- R1: A register write happens on a rising `clk` edge only while `cs_n`=0, `phi2`=1 and `rw`=0. Any other combination changes no register and leaves the held bus byte as it was.
- R2: `dout_oe` is 1 exactly while `cs_n`=0, `phi2`=1, `rw`=1 and `rst`=0. While `dout_oe` is 0, `dout` reads 0.
- R3: Outside reset, at most one register select line is active at a time. A write-only register is never selected by a read, and a read-only register is never selected by a write.
- R4: A write to an address from 0x00 to 0x18 stores `din` in byte lane `addr` of `regs_flat` (bits 8*addr+7..8*addr). No other lane changes.
- R5: While `rst`=1, every edge clears all writable registers and the held bus byte to zero, and `dout_oe` stays 0.
- R6: A write to an address from 0x19 to 0x1F changes no register, but it makes `din` the held bus byte.
- R7: A read of an address from 0x00 to 0x18, or from 0x1D to 0x1F, returns the held bus byte, which is left by the last valid read or write.
- R8: A read of address 0x19+k (k = 0..3) returns lane k of `ro_in` (bits 8k+7..8k) as sampled on the previous `clk` edge, and that byte becomes the held bus byte. Address 0x1B (lane 2) carries the upper waveform byte of the third voice.
- R9: For voice v (v = 0..2), `pulse_width` bits 12v+11..12v are {bits 3..0 of register 7v+3, register 7v+2}. `voice_ctrl` bits 8v+7..8v are register 7v+4, so the third voice's control byte is at 0x12.
- R10: With FADE_CYCLES = 64, after 64 consecutive `clk` edges with neither strobe active, the held bus byte becomes 0. After 63 such edges it is still intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | Transfer direction: 1 read, 0 write |
| phi2 | input | 1 | Bus phase level; transfers qualify only while high |
| addr | input | 5 | Register address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host; zero when released |
| dout_oe | output | 1 | Output enable for the host data pins |
| ro_in | input | 32 | Four read-only source bytes from the voice logic |
| regs_flat | output | 200 | All 25 writable registers, one byte lane per address |
| pulse_width | output | 36 | Three 12-bit pulse widths, voice 0 in the low bits |
| voice_ctrl | output | 24 | Three voice control bytes, voice 0 in the low bits |

## Verification
The assertions watch on every cycle for properties that hold at any moment. These are the one-hot select lines, the output enable seen only under a qualified read, the zero data output when released, and the register file staying frozen when no write strobe fires or when a write targets a read-only or empty address. They also check that a read of a non-readable address returns the held byte, that reset clears the file, and, with an independent idle counter, that the held byte has decayed once the idle window runs out. The bench scenarios show what needs a history of transfers. These are the exact byte a stale read returns after a mix of valid, misdirected and ignored transfers, the one-edge lag of the read-only samples, the packing of the pulse-width and control fields, and the point, one edge either side, at which the held byte fades.

// File: rtl/snd_regbus_pkg.sv
`timescale 1ns/1ps
package snd_regbus_pkg;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_WR   = 2'd1,
      ACC_RD   = 2'd2
   } acc_e;

   // Access class of a register index: writable slots first, then
   // read-only slots, then unimplemented addresses.
   function automatic acc_e acc_of(input int idx, input int n_wr, input int n_rd);
      if (idx < n_wr)
         return ACC_WR;
      else if (idx < n_wr + n_rd)
         return ACC_RD;
      return ACC_NONE;
   endfunction

endpackage

// File: rtl/snd_bus_strobe.sv
`timescale 1ns/1ps
module snd_bus_strobe (
   input  logic rst,
   input  logic cs_n,
   input  logic phi2,
   input  logic rw,
   output logic wr_stb,
   output logic rd_stb
);
   logic qual;

   always_comb begin
      qual   = !cs_n && phi2;
      // Reset forces a write cycle so the clear travels the normal path.
      wr_stb = rst || (qual && !rw);
      rd_stb = !rst && qual && rw;
   end
endmodule

// File: rtl/snd_addr_decode.sv
`timescale 1ns/1ps
module snd_addr_decode #(
   parameter int ADDR_W = 5,
   parameter int N_WR   = 25,
   parameter int N_RD   = 4
) (
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_stb,
   input  logic              rd_stb,
   output logic [N_WR-1:0]   wr_sel,
   output logic [N_RD-1:0]   rd_sel,
   output logic              rd_hit
);
   import snd_regbus_pkg::*;

   for (genvar i = 0; i < N_WR; i++) begin : g_wr
      if (acc_of(i, N_WR, N_RD) == ACC_WR) begin : g_ok
         assign wr_sel[i] = rst || (wr_stb && addr == ADDR_W'(i));
      end else begin : g_none
         assign wr_sel[i] = 1'b0;
      end
   end

   for (genvar k = 0; k < N_RD; k++) begin : g_rd
      localparam int IDX = N_WR + k;
      if (acc_of(IDX, N_WR, N_RD) == ACC_RD) begin : g_ok
         assign rd_sel[k] = rd_stb && addr == ADDR_W'(IDX);
      end else begin : g_none
         assign rd_sel[k] = 1'b0;
      end
   end

   assign rd_hit = |rd_sel;
endmodule

// File: rtl/snd_regfile.sv
`timescale 1ns/1ps
module snd_regfile #(
   parameter int DATA_W = 8,
   parameter int N_WR   = 25,
   parameter int N_RD   = 4
) (
   input  logic                   clk,
   input  logic [N_WR-1:0]        wr_sel,
   input  logic [DATA_W-1:0]      bus_drv,
   input  logic [N_RD-1:0]        rd_sel,
   input  logic [N_RD*DATA_W-1:0] ro_in,
   output logic [N_WR*DATA_W-1:0] regs_flat,
   output logic [DATA_W-1:0]      rd_data
);
   logic [DATA_W-1:0] ro_q [N_RD];

   // Writable lanes: no reset term, reset arrives as select plus zero bus.
   for (genvar i = 0; i < N_WR; i++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_sel[i])
            q <= bus_drv;
      end
      assign regs_flat[i*DATA_W +: DATA_W] = q;
   end

   // Read-only sources sampled once per cycle.
   for (genvar k = 0; k < N_RD; k++) begin : g_ro
      always_ff @(posedge clk) begin
         ro_q[k] <= ro_in[k*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < N_RD; k++) begin
         if (rd_sel[k])
            rd_data = rd_data | ro_q[k];
      end
   end
endmodule

// File: rtl/snd_busdata.sv
`timescale 1ns/1ps
module snd_busdata #(
   parameter int DATA_W      = 8,
   parameter int FADE_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic              rd_stb,
   input  logic              rd_hit,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] bus_drv,
   output logic [DATA_W-1:0] bus_q,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe
);
   logic fade_now;
   logic capture;

   always_comb begin
      if (rst)
         bus_drv = '0;
      else if (wr_stb)
         bus_drv = din;
      else if (rd_hit)
         bus_drv = rd_data;
      else
         bus_drv = bus_q;
      capture = wr_stb || rd_hit;
      dout_oe = rd_stb;
      dout    = rd_stb ? bus_drv : '0;
   end

   if (FADE_CYCLES > 0) begin : g_fade
      localparam int CW = $clog2(FADE_CYCLES + 1);
      localparam logic [CW-1:0] LAST = CW'(FADE_CYCLES - 1);
      logic [CW-1:0] idle_cnt;
      logic          idle;

      assign idle     = !(wr_stb || rd_stb);
      assign fade_now = idle && idle_cnt == LAST;

      always_ff @(posedge clk) begin
         if (rst || !idle)
            idle_cnt <= '0;
         else if (!fade_now)
            idle_cnt <= idle_cnt + 1'b1;
      end
   end else begin : g_nofade
      assign fade_now = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst)
         bus_q <= '0;
      else if (capture)
         bus_q <= bus_drv;
      else if (fade_now)
         bus_q <= '0;
   end
endmodule

// File: rtl/snd_regbus.sv
`timescale 1ns/1ps
module snd_regbus #(
   parameter int ADDR_W       = 5,
   parameter int DATA_W       = 8,
   parameter int N_WR         = 25,
   parameter int N_RD         = 4,
   parameter int N_VOICE      = 3,
   parameter int VOICE_STRIDE = 7,
   parameter int PW_LO_OFS    = 2,
   parameter int PW_HI_OFS    = 3,
   parameter int CTRL_OFS     = 4,
   parameter int PW_W         = 12,
   parameter int FADE_CYCLES  = 64
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cs_n,
   input  logic                      rw,
   input  logic                      phi2,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         din,
   output logic [DATA_W-1:0]         dout,
   output logic                      dout_oe,
   input  logic [N_RD*DATA_W-1:0]    ro_in,
   output logic [N_WR*DATA_W-1:0]    regs_flat,
   output logic [N_VOICE*PW_W-1:0]   pulse_width,
   output logic [N_VOICE*DATA_W-1:0] voice_ctrl
);
   localparam int N_SEL   = N_WR + N_RD;
   localparam int PW_HI_W = PW_W - DATA_W;

   if (N_SEL > (1 << ADDR_W)) begin : g_bad_map
      $error("register count exceeds address space");
   end
   if (N_VOICE * VOICE_STRIDE > N_WR) begin : g_bad_voice
      $error("voice registers exceed writable range");
   end
   if (PW_W <= DATA_W || PW_W > 2 * DATA_W) begin : g_bad_pw
      $error("pulse width must span two bytes");
   end
   if (PW_LO_OFS >= VOICE_STRIDE || PW_HI_OFS >= VOICE_STRIDE ||
       CTRL_OFS >= VOICE_STRIDE) begin : g_bad_ofs
      $error("voice field offset outside stride");
   end
   if (FADE_CYCLES < 0) begin : g_bad_fade
      $error("fade window must be non-negative");
   end

   logic              wr_stb;
   logic              rd_stb;
   logic [N_WR-1:0]   wr_sel;
   logic [N_RD-1:0]   rd_sel;
   logic              rd_hit;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] bus_drv;
   logic [DATA_W-1:0] bus_q;
   logic [N_SEL-1:0]  sel_all;

   snd_bus_strobe u_strobe (
      .rst    (rst),
      .cs_n   (cs_n),
      .phi2   (phi2),
      .rw     (rw),
      .wr_stb (wr_stb),
      .rd_stb (rd_stb)
   );

   snd_addr_decode #(.ADDR_W(ADDR_W), .N_WR(N_WR), .N_RD(N_RD)) u_dec (
      .rst    (rst),
      .addr   (addr),
      .wr_stb (wr_stb),
      .rd_stb (rd_stb),
      .wr_sel (wr_sel),
      .rd_sel (rd_sel),
      .rd_hit (rd_hit)
   );

   snd_busdata #(.DATA_W(DATA_W), .FADE_CYCLES(FADE_CYCLES)) u_bus (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_stb),
      .rd_stb  (rd_stb),
      .rd_hit  (rd_hit),
      .rd_data (rd_data),
      .din     (din),
      .bus_drv (bus_drv),
      .bus_q   (bus_q),
      .dout    (dout),
      .dout_oe (dout_oe)
   );

   snd_regfile #(.DATA_W(DATA_W), .N_WR(N_WR), .N_RD(N_RD)) u_rf (
      .clk       (clk),
      .wr_sel    (wr_sel),
      .bus_drv   (bus_drv),
      .rd_sel    (rd_sel),
      .ro_in     (ro_in),
      .regs_flat (regs_flat),
      .rd_data   (rd_data)
   );

   assign sel_all = {rd_sel, wr_sel};

   for (genvar v = 0; v < N_VOICE; v++) begin : g_voice
      localparam int LO = v * VOICE_STRIDE + PW_LO_OFS;
      localparam int HI = v * VOICE_STRIDE + PW_HI_OFS;
      localparam int CT = v * VOICE_STRIDE + CTRL_OFS;
      assign pulse_width[v*PW_W +: PW_W] =
         {regs_flat[HI*DATA_W +: PW_HI_W], regs_flat[LO*DATA_W +: DATA_W]};
      assign voice_ctrl[v*DATA_W +: DATA_W] = regs_flat[CT*DATA_W +: DATA_W];
   end
endmodule

// File: rtl/snd_regbus_chk.sv
`timescale 1ns/1ps
module snd_regbus_chk #(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int N_WR        = 25,
   parameter int N_RD        = 4,
   parameter int FADE_CYCLES = 64
) (
   input logic                      clk,
   input logic                      rst,
   input logic                      cs_n,
   input logic                      rw,
   input logic                      phi2,
   input logic [ADDR_W-1:0]         addr,
   input logic [DATA_W-1:0]         dout,
   input logic                      dout_oe,
   input logic [N_WR*DATA_W-1:0]    regs_flat,
   input logic                      wr_stb,
   input logic                      rd_stb,
   input logic [N_WR+N_RD-1:0]      sel_all,
   input logic [DATA_W-1:0]         bus_q
);
   // R3
   one_hot_sel_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_all));

   // R2
   oe_qual_chk: assert property (@(posedge clk) disable iff (rst)
      dout_oe |-> (!cs_n && phi2 && rw));

   // R2
   released_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !dout_oe |-> dout == '0);

   // R5
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> regs_flat == '0);

   // R5
   rst_no_oe_chk: assert property (@(posedge clk)
      rst |-> !dout_oe);

   // R1
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_stb |=> $stable(regs_flat));

   // R6
   ro_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_stb && int'(addr) >= N_WR) |=> $stable(regs_flat));

   // R7
   stale_read_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && int'(addr) < N_WR) |-> dout == bus_q);

   if (FADE_CYCLES > 0) begin : g_fade_chk
      localparam int CW = $clog2(FADE_CYCLES + 1);
      logic [CW-1:0] quiet;
      always_ff @(posedge clk) begin
         if (rst || wr_stb || rd_stb)
            quiet <= '0;
         else if (quiet != CW'(FADE_CYCLES))
            quiet <= quiet + 1'b1;
      end
      // R10
      fade_zero_chk: assert property (@(posedge clk) disable iff (rst)
         (quiet == CW'(FADE_CYCLES)) |-> bus_q == '0);
   end
endmodule

bind snd_regbus snd_regbus_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .N_WR        (N_WR),
   .N_RD        (N_RD),
   .FADE_CYCLES (FADE_CYCLES)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cs_n      (cs_n),
   .rw        (rw),
   .phi2      (phi2),
   .addr      (addr),
   .dout      (dout),
   .dout_oe   (dout_oe),
   .regs_flat (regs_flat),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .sel_all   (sel_all),
   .bus_q     (bus_q)
);

// File: tb/tb_snd_regbus.sv
`timescale 1ns/1ps
module tb_snd_regbus;
   localparam int NWR  = 25;
   localparam int NRD  = 4;
   localparam int FADE = 64;

   logic           clk = 1'b0;
   logic           rst;
   logic           cs_n, rw, phi2;
   logic [4:0]     addr;
   logic [7:0]     din;
   logic [7:0]     dout;
   logic           dout_oe;
   logic [31:0]    ro_in;
   logic [199:0]   regs_flat;
   logic [35:0]    pulse_width;
   logic [23:0]    voice_ctrl;

   logic [199:0]   shadow;
   int             n_chk = 0;
   int             n_fail = 0;

   always #2 clk = ~clk;

   snd_regbus dut (
      .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .phi2(phi2),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe),
      .ro_in(ro_in), .regs_flat(regs_flat),
      .pulse_width(pulse_width), .voice_ctrl(voice_ctrl)
   );

   // {is_read, addr, data, expected read byte}
   localparam logic [21:0] VEC [15] = '{
      {1'b0, 5'h02, 8'h34, 8'h00},
      {1'b0, 5'h03, 8'hF7, 8'h00},
      {1'b1, 5'h02, 8'h00, 8'hF7},
      {1'b1, 5'h1B, 8'h00, 8'hA2},
      {1'b1, 5'h12, 8'h00, 8'hA2},
      {1'b0, 5'h1B, 8'h5C, 8'h00},
      {1'b1, 5'h00, 8'h00, 8'h5C},
      {1'b0, 5'h1E, 8'h99, 8'h00},
      {1'b1, 5'h1F, 8'h00, 8'h99},
      {1'b0, 5'h12, 8'h41, 8'h00},
      {1'b1, 5'h19, 8'h00, 8'hA0},
      {1'b1, 5'h1C, 8'h00, 8'hA3},
      {1'b1, 5'h18, 8'h00, 8'hA3},
      {1'b0, 5'h10, 8'h2B, 8'h00},
      {1'b0, 5'h11, 8'h0E, 8'h00}
   };

   task automatic chk(input string req, input logic [199:0] act, input logic [199:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      cs_n = 1'b1; phi2 = 1'b0; rw = 1'b1;
   endtask

   task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; din = d; rw = 1'b0; cs_n = 1'b0; phi2 = 1'b1;
      @(posedge clk); #1;
      go_idle();
      if (int'(a) < NWR) shadow[a*8 +: 8] = d;
   endtask

   task automatic do_rd(input logic [4:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      addr = a; rw = 1'b1; cs_n = 1'b0; phi2 = 1'b1;
      #1; d = dout; oe = dout_oe;
      @(posedge clk); #1;
      go_idle();
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      logic       oe;
      rst = 1'b1; go_idle(); addr = '0; din = '0; shadow = '0;
      ro_in = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
      repeat (3) @(posedge clk);
      // R5: read attempt during reset keeps output released
      @(negedge clk);
      cs_n = 1'b0; phi2 = 1'b1; rw = 1'b1; #1;
      chk("R5 regs clear in reset", regs_flat, '0);
      chk("R5 oe low in reset", 200'(dout_oe), 200'd0);
      go_idle();
      @(negedge clk); rst = 1'b0;
      // R2 idle output released
      #1;
      chk("R2 idle oe", 200'(dout_oe), 200'd0);
      chk("R2 idle dout", 200'(dout), 200'd0);

      // Vector walk: R4 R6 R7 R8
      for (int i = 0; i < 15; i++) begin
         if (VEC[i][21]) begin
            do_rd(VEC[i][20:16], rd, oe);
            chk("R7/R8 read data", 200'(rd), 200'(VEC[i][7:0]));
            chk("R2 oe on read", 200'(oe), 200'd1);
         end else begin
            do_wr(VEC[i][20:16], VEC[i][15:8]);
            chk("R4/R6 register file", regs_flat, shadow);
         end
      end

      // R9 field packing
      chk("R9 pw voice0", 200'(pulse_width[11:0]), 200'h734);
      chk("R9 pw voice2", 200'(pulse_width[35:24]), 200'hE2B);
      chk("R9 ctrl voice2", 200'(voice_ctrl[23:16]), 200'h41);
      chk("R9 ctrl voice0", 200'(voice_ctrl[7:0]), 200'h00);

      // R1: cs_n high and phi2 low writes are ignored
      @(negedge clk);
      addr = 5'h05; din = 8'hEE; rw = 1'b0; cs_n = 1'b1; phi2 = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      cs_n = 1'b0; phi2 = 1'b0; #1;
      chk("R2 oe low with phi2 low", 200'(dout_oe), 200'd0);
      @(posedge clk); #1; go_idle();
      chk("R1 gated writes ignored", regs_flat, shadow);
      do_rd(5'h05, rd, oe);
      chk("R1 bus byte untouched", 200'(rd), 200'h0E);

      // R8 sample lag
      @(negedge clk);
      ro_in[23:16] = 8'h77; addr = 5'h1B; rw = 1'b1; cs_n = 1'b0; phi2 = 1'b1;
      #1; rd = dout;
      @(posedge clk); #1; go_idle();
      chk("R8 old sample", 200'(rd), 200'hA2);
      do_rd(5'h1B, rd, oe);
      chk("R8 new sample", 200'(rd), 200'h77);

      // R10 fade window edges
      do_wr(5'h07, 8'h6D);
      repeat (FADE - 1) @(posedge clk);
      do_rd(5'h07, rd, oe);
      chk("R10 held before window", 200'(rd), 200'h6D);
      repeat (FADE) @(posedge clk);
      do_rd(5'h07, rd, oe);
      chk("R10 faded after window", 200'(rd), 200'h00);

      // R5 mid-run reset
      do_wr(5'h00, 8'hC3);
      @(negedge clk); rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); rst = 1'b0; shadow = '0;
      #1;
      chk("R5 regs cleared", regs_flat, '0);
      chk("R5 pw cleared", 200'(pulse_width), 200'd0);
      do_rd(5'h02, rd, oe);
      chk("R5 bus cleared", 200'(rd), 200'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule